// File: doc/BRIEF.md
# Lookahead Binary Adder

This block adds two unsigned or two's-complement operands and an incoming carry, and it forms every internal carry in one flat step. Each bit position first produces two terms. The first is a "makes a carry" term, the AND of the operand bits. The second is a "makes or passes a carry" term, the OR of the operand bits. A lookahead network then builds the carry into each position as a sum of products. Each product uses only those per-bit terms and the incoming carry, so no carry is taken from the carry of the neighbouring position.

The sum bit of each position is the XOR of its two operand bits and the carry into that position. The carry out of the top position is a separate output. The block has no clock and no state. It is meant to sit between registers in a datapath whose operand width is set by the `WIDTH` parameter (default 4).

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of the arithmetic sum `a_i + b_i + cin_i`, for every combination of inputs.
- R2: `cout_o` equals bit `WIDTH` of the arithmetic sum `a_i + b_i + cin_i`.
- R3: When every bit position has exactly one operand bit set (`a_i ^ b_i` all ones), `cout_o` equals `cin_i` and `sum_o` is all ones when `cin_i` is 0 and all zeros when `cin_i` is 1.
- R4: When both operand bits of the top position (bit `WIDTH-1`) are 1, `cout_o` is 1, whatever the other inputs are.
- R5: When both operand bits of the top position are 0, `cout_o` is 0, whatever the other inputs are.
- R6: With `a_i` zero and `cin_i` 0, `sum_o` equals `b_i` and `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Incoming carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
All 512 combinations of the two 4-bit operands and the incoming carry are applied. Each result is compared against a plain integer addition, so any wrong product term in any carry equation appears as a wrong sum or carry. Within that sweep, some classes of input get extra checks. The all-propagate patterns distinguish a carry that travels the full chain from one that is dropped. Generate and kill patterns at the top bit show that the carry out follows the local terms and not the incoming carry. A zero operand shows that nothing is added spuriously.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // per-bit terms feeding the lookahead network
    typedef struct packed {
        logic gen;   // both operand bits high
        logic gop;   // at least one operand bit high
    } cla_term_t;

    function automatic cla_term_t make_term(input logic x, input logic y);
        cla_term_t t;
        t.gen = x & y;
        t.gop = x | y;
        return t;
    endfunction

endpackage

// File: rtl/cla_term_cell.sv
module cla_term_cell
    import cla_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output cla_term_t        term_o [WIDTH]
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign term_o[i] = make_term(a_i[i], b_i[i]);
    end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net
    import cla_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cla_term_t        term_i [WIDTH],
    input  logic             cin_i,
    output logic [WIDTH:0]   carry_o
);
    assign carry_o[0] = cin_i;

    // carry out of bit k: flattened sum of products, no use of carry k
    for (genvar k = 0; k < WIDTH; k++) begin : g_carry
        logic co_k;
        always_comb begin
            logic prod;
            // product with the incoming carry passed by bits 0..k
            prod = cin_i;
            for (int m = 0; m <= k; m++) prod = prod & term_i[m].gop;
            co_k = prod;
            // product generated at bit j and passed by bits j+1..k
            for (int j = 0; j <= k; j++) begin
                prod = term_i[j].gen;
                for (int m = j + 1; m <= k; m++) prod = prod & term_i[m].gop;
                co_k = co_k | prod;
            end
        end
        assign carry_o[k+1] = co_k;
    end
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] cin_bits_i,
    output logic [WIDTH-1:0] sum_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ cin_bits_i[i];
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    cla_term_t        terms [WIDTH];
    logic [WIDTH:0]   carries;

    cla_term_cell #(.WIDTH(WIDTH)) u_terms (
        .a_i    (a_i),
        .b_i    (b_i),
        .term_o (terms)
    );

    cla_carry_net #(.WIDTH(WIDTH)) u_net (
        .term_i  (terms),
        .cin_i   (cin_i),
        .carry_o (carries)
    );

    cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .a_i        (a_i),
        .b_i        (b_i),
        .cin_bits_i (carries[WIDTH-1:0]),
        .sum_o      (sum_o)
    );

    assign cout_o = carries[WIDTH];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o
);
    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        // R1
        sum_match_chk: assert (sum_o == ref_total[WIDTH-1:0]);
        // R2
        carry_match_chk: assert (cout_o == ref_total[WIDTH]);
        // R3
        if ((a_i ^ b_i) == {WIDTH{1'b1}})
            full_pass_chk: assert (cout_o == cin_i);
        // R4
        if (a_i[WIDTH-1] && b_i[WIDTH-1])
            top_gen_chk: assert (cout_o);
        // R5
        if (!a_i[WIDTH-1] && !b_i[WIDTH-1])
            top_kill_chk: assert (!cout_o);
    end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/sim_cla_adder.sv
module sim_cla_adder;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int MAX_CYCLES = 5000;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         c;
        logic [W-1:0] exp_sum;
        logic         exp_cout;
    } item_t;

    logic clk = 1'b0;
    logic [W-1:0] a, b, sum;
    logic cin, cout;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder #(.WIDTH(W)) u0 (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     req, a, b, cin, act, exp);
        end
    endtask

    // driver: applies each vector and pushes its expected result
    task automatic drive(input int av, input int bv, input int cv);
        item_t it;
        int total;
        @(posedge clk);
        a = av[W-1:0]; b = bv[W-1:0]; cin = cv[0];
        total = av + bv + cv;
        it.a = a; it.b = b; it.c = cin;
        it.exp_sum = total[W-1:0];
        it.exp_cout = total[W];
        q.push_back(it);
    endtask

    // monitor: compares at the falling edge, after inputs have settled
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check("R1 sum", int'(sum), int'(it.exp_sum));
            check("R2 carry", int'(cout), int'(it.exp_cout));
            if ((it.a ^ it.b) == {W{1'b1}}) begin
                check("R3 pass cout", int'(cout), int'(it.c));
                check("R3 pass sum", int'(sum), it.c ? 0 : (1 << W) - 1);
            end
            if (it.a[W-1] && it.b[W-1]) check("R4 top generate", int'(cout), 1);
            if (!it.a[W-1] && !it.b[W-1]) check("R5 top kill", int'(cout), 0);
            if (it.a == '0 && !it.c) begin
                check("R6 zero sum", int'(sum), int'(it.b));
                check("R6 zero cout", int'(cout), 0);
            end
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        // idle state with all-zero inputs
        #(CLK_PERIOD/4);
        check("R1 idle sum", int'(sum), 0);
        check("R2 idle carry", int'(cout), 0);
        for (int cv = 0; cv < 2; cv++)
            for (int av = 0; av < (1 << W); av++)
                for (int bv = 0; bv < (1 << W); bv++)
                    drive(av, bv, cv);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule